// File: doc/BRIEF.md
# Prioritized Result-Bus Arbiter

This block decides which of several producers may drive a shared result bus in a given clock. Three producers share the bus: the multiply/divide unit, the add unit and the instruction decoder. A producer raises its request together with a non-zero result tag and a data word. It holds all three steady until it sees its acknowledge. The arbiter grants one producer per clock, and the producer with the lowest index wins. It then broadcasts the winner's tag and data for exactly one cycle, with the acknowledge in that same cycle.

Requests that arrive together are not dropped. The losers stay held and are served in the next cycles, in priority order. The grant decision is registered. A request sampled at one clock edge therefore appears on the bus, with its acknowledge, in the cycle that follows that edge. During the acknowledge cycle the acknowledged producer is masked, so a held request cannot be granted twice. Tag matching in registers and stations downstream, and the producers' own logic, belong to other blocks.

Top module: `cdb_result_arbiter`

## Requirements
- R1: While the synchronous active-low reset is sampled low, and in the cycle after it, `req_ack` is all zero and `bus_valid` is 0.
- R2: At most one bit of `req_ack` is set in any cycle, and `bus_valid` is 1 exactly when one bit of `req_ack` is set.
- R3: Requester indices are fixed: bit 0 is the multiply/divide unit, bit 1 is the add unit and bit 2 is the decoder. Among the eligible requests sampled at an edge, the lowest index is granted.
- R4: A request sampled at a rising edge is acknowledged and broadcast in the cycle that directly follows that edge. Nothing is acknowledged without a request sampled at the previous edge.
- R5: In a broadcast cycle, `bus_tag` and `bus_data` equal the tag and data that the granted requester presented at the sampling edge, and `bus_src` equals its index.
- R6: A requester whose acknowledge is high is not eligible at the edge that ends that cycle, so no requester is acknowledged in two consecutive cycles.
- R7: A request that is eligible but not granted at an edge is served later, never lost: every eligible edge is followed by a broadcast cycle, and each held request is acknowledged exactly once.
- R8: A request whose tag is zero is not eligible. It is never acknowledged, and `bus_tag` is never zero while `bus_valid` is 1.
- R9: A requester with a non-zero tag that is not acknowledged must keep its request high and its tag and data unchanged at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_REQ | Request per producer, bit 0 highest priority |
| req_tag | input | NUM_REQ*TAG_W | Result tags, producer i at bits [i*TAG_W +: TAG_W] |
| req_data | input | NUM_REQ*DATA_W | Result data, producer i at bits [i*DATA_W +: DATA_W] |
| req_ack | output | NUM_REQ | One-hot acknowledge to the producer being broadcast |
| bus_valid | output | 1 | Broadcast valid, high for one cycle per grant |
| bus_tag | output | TAG_W | Broadcast tag |
| bus_data | output | DATA_W | Broadcast data |
| bus_src | output | SRC_W | Index of the producer being broadcast |

## Verification
The assertions assume the producers keep the held-until-acknowledge protocol. A producer holding a non-zero tag keeps its request, tag and data unchanged until it sees its acknowledge. A producer that presents a zero tag may withdraw it at any time. The stimulus respects this because each bench producer drives the head of its own queue, and it pops that head only at the falling edge where the acknowledge is visible. Withdrawing is only done for zero-tag requests, and a reset applied mid-run leaves every held request in place.

// File: rtl/cdb_arb_pkg.sv
// Package: cdb_arb_pkg
// Shared defaults and helpers for the result-bus arbiter.
// Assumes: requester indices are ordered by priority, index 0 highest.
package cdb_arb_pkg;

    // Default number of producers sharing the bus
    localparam int ARB_NUM_REQ = 3;
    // Default result tag width (tag 0 means "no tag")
    localparam int ARB_TAG_W   = 4;
    // Default result data width
    localparam int ARB_DATA_W  = 32;

    // Producer indices in priority order
    typedef enum logic [1:0] {
        SRC_MULDIV = 2'd0,
        SRC_ADDER  = 2'd1,
        SRC_DECODE = 2'd2
    } arb_src_e;

    // Width of an index over n items, at least one bit
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cdb_prio_pick.sv
// Module: cdb_prio_pick
// Fixed-priority picker: grants the lowest-indexed set request bit.
// Assumes: the caller has already masked requests that may not compete.
// Outputs are purely combinational.
module cdb_prio_pick #(
    parameter int N     = 3,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // Prefix OR: seen[i] is set when any request at index <= i is set
    logic [N-1:0] seen;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_chain
            if (gi == 0) begin : g_first
                // Index 0 wins whenever it requests
                assign grant[gi] = req[gi];
                assign seen[gi]  = req[gi];
            end else begin : g_rest
                // Later index wins only if nothing ahead of it requests
                assign grant[gi] = req[gi] & ~seen[gi-1];
                assign seen[gi]  = seen[gi-1] | req[gi];
            end
        end
    endgenerate

    assign any = seen[N-1];

    // Encode the one-hot grant into an index
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/cdb_bus_mux.sv
// Module: cdb_bus_mux
// AND-OR selector that picks one producer's tag and data by a one-hot grant.
// Assumes: grant is one-hot or zero. With zero grant the outputs are zero.
module cdb_bus_mux #(
    parameter int N      = 3,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic [N-1:0]        grant,
    input  logic [N*TAG_W-1:0]  tag_flat,
    input  logic [N*DATA_W-1:0] data_flat,
    output logic [TAG_W-1:0]    tag_sel,
    output logic [DATA_W-1:0]   data_sel
);

    // OR together each producer's fields gated by its grant bit
    always_comb begin
        tag_sel  = '0;
        data_sel = '0;
        for (int i = 0; i < N; i++) begin
            tag_sel  = tag_sel  | (tag_flat[i*TAG_W +: TAG_W]    & {TAG_W{grant[i]}});
            data_sel = data_sel | (data_flat[i*DATA_W +: DATA_W] & {DATA_W{grant[i]}});
        end
    end

endmodule

// File: rtl/cdb_bcast_stage.sv
// Module: cdb_bcast_stage
// Output register stage: holds the acknowledge vector, the broadcast valid
// flag and the broadcast payload for one cycle per grant.
// Assumes: grant is one-hot or zero, and any equals the OR of grant.
// The payload registers load only on a grant, so they keep their last value
// while valid is low.
module cdb_bcast_stage #(
    parameter int N      = 3,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32,
    parameter int SRC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      grant,
    input  logic              any,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [SRC_W-1:0]  src_in,
    output logic [N-1:0]      ack_q,
    output logic              valid_q,
    output logic [TAG_W-1:0]  tag_q,
    output logic [DATA_W-1:0] data_q,
    output logic [SRC_W-1:0]  src_q
);

    // Control flops: acknowledge and valid, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            ack_q   <= grant;
            valid_q <= any;
        end
    end

    // Payload flops: load the winner's fields only on a grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            data_q <= '0;
            src_q  <= '0;
        end else if (any) begin
            tag_q  <= tag_in;
            data_q <= data_in;
            src_q  <= src_in;
        end
    end

endmodule

// File: rtl/cdb_result_arbiter.sv
// Module: cdb_result_arbiter
// Fixed-priority arbiter for a shared result broadcast bus.
// Each producer holds request, tag and data until acknowledged. At each edge
// the lowest-indexed eligible producer is granted. Its tag and data are
// broadcast, with its acknowledge, in the following cycle.
// A request is eligible when it has a non-zero tag and its producer is not
// being acknowledged in the current cycle. The second condition stops a
// held request from being served twice.
// Assumes: synchronous active-low reset; producers keep the
// held-until-acknowledge protocol.
module cdb_result_arbiter
    import cdb_arb_pkg::*;
#(
    parameter int NUM_REQ = ARB_NUM_REQ,
    parameter int TAG_W   = ARB_TAG_W,
    parameter int DATA_W  = ARB_DATA_W,
    parameter int SRC_W   = idx_width(NUM_REQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        req_valid,
    input  logic [NUM_REQ*TAG_W-1:0]  req_tag,
    input  logic [NUM_REQ*DATA_W-1:0] req_data,
    output logic [NUM_REQ-1:0]        req_ack,
    output logic                      bus_valid,
    output logic [TAG_W-1:0]          bus_tag,
    output logic [DATA_W-1:0]         bus_data,
    output logic [SRC_W-1:0]          bus_src
);

    logic [NUM_REQ-1:0] eligible;
    logic [NUM_REQ-1:0] grant;
    logic [SRC_W-1:0]   grant_idx;
    logic               grant_any;
    logic [TAG_W-1:0]   win_tag;
    logic [DATA_W-1:0]  win_data;
    logic [NUM_REQ-1:0] ack_q;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REQ; gi++) begin : g_elig
            // A request competes if it has a real tag and is not in its ack cycle
            assign eligible[gi] = req_valid[gi]
                                & (req_tag[gi*TAG_W +: TAG_W] != '0)
                                & ~ack_q[gi];
        end
    endgenerate

    cdb_prio_pick #(
        .N     (NUM_REQ),
        .IDX_W (SRC_W)
    ) u_pick (
        .req   (eligible),
        .grant (grant),
        .idx   (grant_idx),
        .any   (grant_any)
    );

    cdb_bus_mux #(
        .N      (NUM_REQ),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_mux (
        .grant     (grant),
        .tag_flat  (req_tag),
        .data_flat (req_data),
        .tag_sel   (win_tag),
        .data_sel  (win_data)
    );

    cdb_bcast_stage #(
        .N      (NUM_REQ),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W),
        .SRC_W  (SRC_W)
    ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant   (grant),
        .any     (grant_any),
        .tag_in  (win_tag),
        .data_in (win_data),
        .src_in  (grant_idx),
        .ack_q   (ack_q),
        .valid_q (bus_valid),
        .tag_q   (bus_tag),
        .data_q  (bus_data),
        .src_q   (bus_src)
    );

    assign req_ack = ack_q;

endmodule

// File: rtl/cdb_arb_checker.sv
// Module: cdb_arb_checker
// Protocol and arbitration properties for cdb_result_arbiter, bound to it.
// Assumes: the same parameters as the arbiter instance it is attached to.
module cdb_arb_checker #(
    parameter int NUM_REQ = 3,
    parameter int TAG_W   = 4,
    parameter int DATA_W  = 32,
    parameter int SRC_W   = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_REQ-1:0]        req_valid,
    input logic [NUM_REQ*TAG_W-1:0]  req_tag,
    input logic [NUM_REQ*DATA_W-1:0] req_data,
    input logic [NUM_REQ-1:0]        req_ack,
    input logic                      bus_valid,
    input logic [TAG_W-1:0]          bus_tag,
    input logic [SRC_W-1:0]          bus_src
);

    // Requests seen by the checker as able to compete
    logic [NUM_REQ-1:0] live;

    genvar gi, gj;
    generate
        for (gi = 0; gi < NUM_REQ; gi++) begin : g_live
            assign live[gi] = req_valid[gi] & (req_tag[gi*TAG_W +: TAG_W] != '0);
        end
    endgenerate

    // R2: one acknowledge at most, tied to the valid flag
    assert_one_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ack));
    assert_valid_with_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid == ($countones(req_ack) == 1));

    // R5: the source index names the acknowledged producer
    assert_src_matches_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (req_ack == (NUM_REQ'(1) << bus_src)));

    // R8: a zero tag never goes out
    assert_nonzero_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_tag != '0));

    // R7: an eligible edge is always followed by a broadcast
    assert_no_lost_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(live & ~req_ack)) |=> bus_valid);

    generate
        for (gi = 0; gi < NUM_REQ; gi++) begin : g_per_req
            // R4: an acknowledge follows a live request one edge earlier
            assert_ack_needs_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
                req_ack[gi] |-> $past(live[gi]));

            // R6: no producer is acknowledged twice in a row
            assert_no_double_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
                req_ack[gi] |=> !req_ack[gi]);

            // R9: a held, unacknowledged request keeps its fields
            assert_held_request_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (live[gi] && !req_ack[gi]) |=>
                    (req_ack[gi] ||
                     (req_valid[gi] &&
                      $stable(req_tag[gi*TAG_W +: TAG_W]) &&
                      $stable(req_data[gi*DATA_W +: DATA_W]))));

            for (gj = 0; gj < gi; gj++) begin : g_higher
                // R3: a lower index that could compete blocks this grant
                assert_priority_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
                    req_ack[gi] |-> !$past(live[gj] && !req_ack[gj]));
            end
        end
    endgenerate

endmodule

bind cdb_result_arbiter cdb_arb_checker #(
    .NUM_REQ (NUM_REQ),
    .TAG_W   (TAG_W),
    .DATA_W  (DATA_W),
    .SRC_W   (SRC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_tag   (req_tag),
    .req_data  (req_data),
    .req_ack   (req_ack),
    .bus_valid (bus_valid),
    .bus_tag   (bus_tag),
    .bus_src   (bus_src)
);

// File: tb/tb_cdb_result_arbiter.sv
`timescale 1ns/1ps
// Bench for cdb_result_arbiter: queued producers and a behavioural
// reference model compared at every falling edge.
module tb_cdb_result_arbiter;

    localparam int NR = 3;
    localparam int TW = 4;
    localparam int DW = 32;
    localparam int SW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NR-1:0]     req_valid = '0;
    logic [NR*TW-1:0]  req_tag = '0;
    logic [NR*DW-1:0]  req_data = '0;
    logic [NR-1:0]     req_ack;
    logic              bus_valid;
    logic [TW-1:0]     bus_tag;
    logic [DW-1:0]     bus_data;
    logic [SW-1:0]     bus_src;

    always #4 clk = ~clk;

    cdb_result_arbiter #(.NUM_REQ(NR), .TAG_W(TW), .DATA_W(DW), .SRC_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
        .req_data(req_data), .req_ack(req_ack), .bus_valid(bus_valid),
        .bus_tag(bus_tag), .bus_data(bus_data), .bus_src(bus_src)
    );

    // Producer queues of {tag, data}
    logic [TW+DW-1:0] pend [NR][$];
    int pushed [NR];
    int served [NR];
    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done = 0;
    bit rst_seen = 0;
    int dec_zero_cycles = 0;
    bit zero_phase = 0;
    int zero_phase_acks = 0;
    logic [NR-1:0] prev_ack = '0;

    // Reference model state
    logic [NR-1:0] exp_ack = '0;
    bit            exp_v = 0;
    logic [TW-1:0] exp_tag = '0;
    logic [DW-1:0] exp_data = '0;
    int            exp_src = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    task automatic push(input int i, input logic [TW-1:0] t, input logic [DW-1:0] d);
        pend[i].push_back({t, d});
        pushed[i]++;
    endtask

    function automatic int total_pending();
        int s = 0;
        for (int i = 0; i < NR; i++) s += pend[i].size();
        return s;
    endfunction

    task automatic wait_idle();
        while (total_pending() > 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    // Reference model: lowest-index eligible request wins, acked one masked
    always @(posedge clk) begin
        int win;
        started = 1;
        rst_seen = !rst_n;
        if (!rst_n) begin
            exp_ack = '0;
            exp_v = 0;
        end else begin
            win = -1;
            for (int i = 0; i < NR; i++)
                if (win < 0 && req_valid[i] && req_tag[i*TW +: TW] != 0 && !exp_ack[i])
                    win = i;
            exp_ack = '0;
            exp_v = 0;
            if (win >= 0) begin
                exp_ack[win] = 1'b1;
                exp_v = 1;
                exp_tag = req_tag[win*TW +: TW];
                exp_data = req_data[win*DW +: DW];
                exp_src = win;
            end
        end
    end

    // Compare, retire acknowledged items, drive the next requests
    always @(negedge clk) begin
        logic [TW+DW-1:0] head;
        if (started && !done) begin
            check(req_ack == exp_ack, rst_seen ? "R1" : "R3", "ack vector",
                  longint'(req_ack), longint'(exp_ack));
            check(bus_valid == exp_v, rst_seen ? "R1" : "R4", "bus_valid",
                  longint'(bus_valid), longint'(exp_v));
            check($onehot0(req_ack) && (bus_valid == (req_ack != 0)), "R2",
                  "ack/valid coherence", longint'(req_ack), longint'(bus_valid));
            if (exp_v) begin
                check(bus_tag == exp_tag, "R5", "bus_tag", longint'(bus_tag), longint'(exp_tag));
                check(bus_data == exp_data, "R5", "bus_data", longint'(bus_data), longint'(exp_data));
                check(int'(bus_src) == exp_src, "R5", "bus_src", longint'(bus_src), longint'(exp_src));
            end
            if (bus_valid)
                check(bus_tag != 0, "R8", "zero tag broadcast", longint'(bus_tag), 1);
            check((prev_ack & req_ack) == 0, "R6", "back-to-back ack",
                  longint'(req_ack), longint'(req_ack & ~prev_ack));
            prev_ack = req_ack;
            for (int i = 0; i < NR; i++) begin
                if (req_ack[i]) begin
                    if (pend[i].size() > 0) begin
                        head = pend[i][0];
                        check({bus_tag, bus_data} == head, "R7", "served item order",
                              longint'({bus_tag, bus_data}), longint'(head));
                        void'(pend[i].pop_front());
                        served[i]++;
                    end else begin
                        check(0, "R8", "ack without held item", longint'(req_ack), 0);
                    end
                end
            end
            if (zero_phase && req_ack[2]) zero_phase_acks++;
        end
        for (int i = 0; i < NR; i++) begin
            if (pend[i].size() > 0) begin
                head = pend[i][0];
                req_valid[i] = 1'b1;
                req_tag[i*TW +: TW] = head[TW+DW-1:DW];
                req_data[i*DW +: DW] = head[DW-1:0];
            end else if (i == 2 && dec_zero_cycles > 0) begin
                req_valid[i] = 1'b1;
                req_tag[i*TW +: TW] = '0;
                req_data[i*DW +: DW] = 32'hBAD0_0000 + dec_zero_cycles;
                dec_zero_cycles--;
            end else begin
                req_valid[i] = 1'b0;
                req_tag[i*TW +: TW] = '0;
                req_data[i*DW +: DW] = '0;
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R7 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int lfsr = 32'h1ACE;
        for (int i = 0; i < NR; i++) begin pushed[i] = 0; served[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet under reset
        check(req_ack == 0 && bus_valid == 0, "R1", "reset state",
              longint'({req_ack, bus_valid}), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;

        // Each producer alone (R4, R5)
        push(0, 4'h3, 32'h1111_0001); wait_idle();
        push(1, 4'h5, 32'h2222_0002); wait_idle();
        push(2, 4'h7, 32'h3333_0003); wait_idle();

        // All three together: multiply, add, decoder in consecutive cycles (R3, R7)
        push(2, 4'h9, 32'hD0D0_0001);
        push(1, 4'hA, 32'hADD0_0001);
        push(0, 4'hB, 32'hA110_0001);
        wait_idle();

        // Back-to-back multiply items with add waiting: interleave (R6)
        for (int k = 0; k < 4; k++) push(0, 4'(k + 1), 32'h5000_0000 + k);
        for (int k = 0; k < 2; k++) push(1, 4'(k + 8), 32'h6000_0000 + k);
        push(2, 4'hF, 32'h7000_0000);
        wait_idle();

        // Zero-tag decoder request is ignored while add is served (R8)
        zero_phase = 1;
        dec_zero_cycles = 6;
        push(1, 4'h2, 32'h0BAD_0002);
        repeat (9) @(posedge clk);
        #1;
        check(zero_phase_acks == 0, "R8", "zero-tag request acked",
              longint'(zero_phase_acks), 0);
        zero_phase = 0;
        wait_idle();

        // Reset while requests are held (R1), then completion (R7)
        push(0, 4'h4, 32'hEE00_0000);
        push(1, 4'h6, 32'hEE00_0001);
        push(2, 4'h8, 32'hEE00_0002);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        wait_idle();

        // Pseudo-random traffic
        for (int c = 0; c < 3000; c++) begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            for (int i = 0; i < NR; i++)
                if (lfsr[i*3 +: 2] != 0 && pend[i].size() < 4)
                    push(i, 4'((lfsr[i*4 + 8 +: 4] % 15) + 1), lfsr ^ (c << 8) ^ i);
        end
        wait_idle();

        // R7: every pushed item served exactly once
        for (int i = 0; i < NR; i++)
            check(served[i] == pushed[i] && pend[i].size() == 0, "R7",
                  "served count", longint'(served[i]), longint'(pushed[i]));
        finish_run();
    end

endmodule